// File: doc/BRIEF.md
# PHY Register Bank with UART Passthrough

This block is a small register bank inside a USB transceiver. It is reached over a plain byte bus with an address, a write strobe, write data and registered read data. It holds two registers. The first is a free 8-bit scratch byte. The second is a carkit control byte whose two routing bits can hand the data pins over to a UART. Each register answers at three consecutive addresses. A write to the first address loads the byte. A write to the second ORs the data into the byte. A write to the third clears every bit that is 1 in the data.

UART passthrough is active while the carkit-mode input is high and at least one routing bit is set. In that state the transmit route copies the `data0_in` pin onto `dm_out`, and the receive route copies `dp_in` onto `data1_out`. Every pin that is not routed carries the normal-mode value supplied by the rest of the PHY. While passthrough is active the register bus is dead: writes are dropped and the read data holds its value. A pulse on `stop`, or a reset, ends passthrough and clears both routing bits.

Top module: `phy_uart_regbank`

## Requirements
- R1: After reset both registers hold 00h, `reg_rdata` is 00h, `dm_out` equals `dm_norm` and `data1_out` equals `data1_norm`.
- R2: Scratch register: a write to 16h loads the data, a write to 17h ORs the data in, and a write to 18h clears the bits that are 1 in the data.
- R3: Carkit control register: 19h loads, 1Ah sets and 1Bh clears. Only bit 3 (receive route) and bit 2 (transmit route) can store a 1. The other bits always read 0.
- R4: The read data is registered. The value of the register selected by the address in one cycle appears on `reg_rdata` after the next clock edge. Each of a register's three addresses returns the same value. An unmapped address reads 00h.
- R5: While `carkit_mode` is 1 and bit 2 is set, `dm_out` follows `data0_in` combinationally. Otherwise `dm_out` equals `dm_norm`.
- R6: While `carkit_mode` is 1 and bit 3 is set, `data1_out` follows `dp_in` combinationally. Otherwise `data1_out` equals `data1_norm`.
- R7: While `carkit_mode` is 0, the routing bits can be written and read back but route no pin.
- R8: While passthrough is active, bus writes change no register and `reg_rdata` holds its value.
- R9: A `stop` pulse while passthrough is active clears bits 3 and 2 at that clock edge, so both pins fall back from the next cycle. A reset during passthrough also clears both bits.
- R10: The scratch register affects no pin, whatever value it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| carkit_mode | input | 1 | Interface-control bit that allows passthrough |
| stop | input | 1 | Ends passthrough |
| data0_in | input | 1 | UART transmit source pin |
| dp_in | input | 1 | UART receive source line |
| dm_norm | input | 1 | Normal-mode value for the DM line |
| data1_norm | input | 1 | Normal-mode value for the DATA1 pin |
| dm_out | output | 1 | DM line drive |
| data1_out | output | 1 | DATA1 pin drive |

## Verification
A wrong routing bit shows on `dm_out` or `data1_out` in the same cycle, because the pin mux is combinational. A wrong register byte shows one clock after the byte is addressed, through the registered read path. Writes that leak in during passthrough cannot be seen while the bus is dead. They show on the first read after `stop`, as a scratch value that changed or a routing bit that survived.

// File: rtl/phy_uart_regbank_pkg.sv
package phy_uart_regbank_pkg;

    localparam int DW = 8;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } alias_op_e;

    typedef struct packed {
        logic      hit;
        alias_op_e op;
    } alias_dec_t;

    typedef struct packed {
        logic [DW-1:0] rdata;
    } top_state_t;

endpackage

// File: rtl/alias_decode.sv
module alias_decode
    import phy_uart_regbank_pkg::*;
#(
    parameter int          AW   = 8,
    parameter logic [AW-1:0] BASE = '0
) (
    input  logic [AW-1:0] addr,
    input  logic          we,
    output alias_dec_t    dec
);
    localparam logic [AW-1:0] SPAN = AW'(3);

    logic [AW-1:0] offset;

    always_comb begin
        offset  = addr - BASE;
        dec.hit = (addr >= BASE) && (offset < SPAN);
        dec.op  = OP_NONE;
        if (dec.hit && we) begin
            unique case (offset[1:0])
                2'd0:    dec.op = OP_LOAD;
                2'd1:    dec.op = OP_SET;
                default: dec.op = OP_CLEAR;
            endcase
        end
    end
endmodule

// File: rtl/alias_reg.sv
module alias_reg
    import phy_uart_regbank_pkg::*;
#(
    parameter int           W        = 8,
    parameter logic [W-1:0] KEEP     = '1,
    parameter logic [W-1:0] RST_VAL  = '0,
    parameter logic [W-1:0] AUTO_CLR = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  alias_op_e    op,
    input  logic [W-1:0] wdata,
    input  logic         auto_clr,
    output logic [W-1:0] q
);
    logic [W-1:0] val_d;
    logic [W-1:0] val_q;

    always_comb begin
        val_d = val_q;
        if (en) begin
            unique case (op)
                OP_LOAD:  val_d = wdata;
                OP_SET:   val_d = val_q | wdata;
                OP_CLEAR: val_d = val_q & ~wdata;
                default:  val_d = val_q;
            endcase
        end
        if (auto_clr) begin
            val_d = val_d & ~AUTO_CLR;
        end
        val_d = val_d & KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= RST_VAL & KEEP;
        else        val_q <= val_d;
    end

    assign q = val_q;
endmodule

// File: rtl/uart_route.sv
module uart_route #(
    parameter int TX_BIT = 2,
    parameter int RX_BIT = 3,
    parameter int W      = 8
) (
    input  logic [W-1:0] ctrl,
    input  logic         carkit_mode,
    input  logic         data0_in,
    input  logic         dp_in,
    input  logic         dm_norm,
    input  logic         data1_norm,
    output logic         dm_out,
    output logic         data1_out,
    output logic         uart_active
);
    logic tx_on;
    logic rx_on;

    always_comb begin
        tx_on       = carkit_mode & ctrl[TX_BIT];
        rx_on       = carkit_mode & ctrl[RX_BIT];
        uart_active = tx_on | rx_on;
        dm_out      = tx_on ? data0_in : dm_norm;
        data1_out   = rx_on ? dp_in    : data1_norm;
    end
endmodule

// File: rtl/phy_uart_regbank.sv
module phy_uart_regbank
    import phy_uart_regbank_pkg::*;
#(
    parameter int           AW      = 8,
    parameter logic [AW-1:0] SCR_BASE = 8'h16,
    parameter logic [AW-1:0] CK_BASE  = 8'h19,
    parameter int           TX_BIT  = 2,
    parameter int           RX_BIT  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_we,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          carkit_mode,
    input  logic          stop,
    input  logic          data0_in,
    input  logic          dp_in,
    input  logic          dm_norm,
    input  logic          data1_norm,
    output logic          dm_out,
    output logic          data1_out
);
    localparam logic [DW-1:0] ROUTE_MASK = (DW'(1) << TX_BIT) | (DW'(1) << RX_BIT);

    alias_dec_t    scr_dec;
    alias_dec_t    ck_dec;
    logic [DW-1:0] scr_q;
    logic [DW-1:0] ck_q;
    logic          uart_active;
    logic          bus_en;
    logic          end_uart;
    top_state_t    st_d;
    top_state_t    st_q;

    assign bus_en   = reg_we & ~uart_active;
    assign end_uart = uart_active & stop;

    alias_decode #(.AW(AW), .BASE(SCR_BASE)) u_scr_dec (
        .addr(reg_addr), .we(reg_we), .dec(scr_dec)
    );

    alias_decode #(.AW(AW), .BASE(CK_BASE)) u_ck_dec (
        .addr(reg_addr), .we(reg_we), .dec(ck_dec)
    );

    alias_reg #(.W(DW), .KEEP('1), .RST_VAL('0), .AUTO_CLR('0)) u_scr (
        .clk(clk), .rst_n(rst_n), .en(bus_en), .op(scr_dec.op),
        .wdata(reg_wdata), .auto_clr(1'b0), .q(scr_q)
    );

    alias_reg #(.W(DW), .KEEP(ROUTE_MASK), .RST_VAL('0), .AUTO_CLR(ROUTE_MASK)) u_ck (
        .clk(clk), .rst_n(rst_n), .en(bus_en), .op(ck_dec.op),
        .wdata(reg_wdata), .auto_clr(end_uart), .q(ck_q)
    );

    uart_route #(.TX_BIT(TX_BIT), .RX_BIT(RX_BIT), .W(DW)) u_route (
        .ctrl(ck_q), .carkit_mode(carkit_mode), .data0_in(data0_in),
        .dp_in(dp_in), .dm_norm(dm_norm), .data1_norm(data1_norm),
        .dm_out(dm_out), .data1_out(data1_out), .uart_active(uart_active)
    );

    always_comb begin
        st_d = st_q;
        if (!uart_active) begin
            if (scr_dec.hit)     st_d.rdata = scr_q;
            else if (ck_dec.hit) st_d.rdata = ck_q;
            else                 st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;
endmodule

// File: rtl/phy_uart_regbank_chk.sv
module phy_uart_regbank_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] reg_addr,
    input logic [7:0] reg_rdata,
    input logic       carkit_mode,
    input logic       stop,
    input logic       dm_norm,
    input logic       data1_norm,
    input logic       dm_out,
    input logic       data1_out,
    input logic       uart_active
);
    a_r3_reserved_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_addr) >= 8'h19 && $past(reg_addr) <= 8'h1B && !$past(uart_active))
        |-> ((reg_rdata & 8'hF3) == 8'h00));

    a_r4_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(reg_addr) < 8'h16 || $past(reg_addr) > 8'h1B) && !$past(uart_active))
        |-> (reg_rdata == 8'h00));

    a_r7_no_route_without_mode: assert property (@(posedge clk) disable iff (!rst_n)
        !carkit_mode |-> (dm_out == dm_norm && data1_out == data1_norm));

    a_r8_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        uart_active |=> $stable(reg_rdata));

    a_r9_stop_ends_uart: assert property (@(posedge clk) disable iff (!rst_n)
        (uart_active && stop) |=> !uart_active);
endmodule

bind phy_uart_regbank phy_uart_regbank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .carkit_mode(carkit_mode), .stop(stop), .dm_norm(dm_norm),
    .data1_norm(data1_norm), .dm_out(dm_out), .data1_out(data1_out),
    .uart_active(uart_active)
);

// File: tb/sim_phy_uart_regbank.sv
`timescale 1ns/1ps
module sim_phy_uart_regbank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       carkit_mode = 1'b0;
    logic       stop = 1'b0;
    logic       data0_in = 1'b0;
    logic       dp_in = 1'b0;
    logic       dm_norm = 1'b0;
    logic       data1_norm = 1'b0;
    logic       dm_out;
    logic       data1_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    phy_uart_regbank u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .carkit_mode(carkit_mode),
        .stop(stop), .data0_in(data0_in), .dp_in(dp_in), .dm_norm(dm_norm),
        .data1_norm(data1_norm), .dm_out(dm_out), .data1_out(data1_out)
    );

    // {address, write data, expected read-back}
    localparam int NV = 10;
    localparam logic [23:0] VEC [NV] = '{
        {8'h16, 8'hA5, 8'hA5},   // R2 load
        {8'h17, 8'h5A, 8'hFF},   // R2 set
        {8'h18, 8'h0F, 8'hF0},   // R2 clear
        {8'h16, 8'h3C, 8'h3C},   // R2 load
        {8'h18, 8'hFF, 8'h00},   // R2 clear all
        {8'h19, 8'hFF, 8'h0C},   // R3 load, reserved masked
        {8'h1B, 8'h04, 8'h08},   // R3 clear bit 2
        {8'h1A, 8'hF3, 8'h08},   // R3 set reserved only
        {8'h1A, 8'h04, 8'h0C},   // R3 set bit 2
        {8'h19, 8'h00, 8'h00}    // R3 load zero
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b0;
        @(negedge clk);
        v = reg_rdata;
    endtask

    task automatic pins(input string req, input logic e_dm, input logic e_d1);
        #1;
        check8(req, {6'b0, dm_out, data1_out}, {6'b0, e_dm, e_d1});
    endtask

    initial begin
        logic [7:0] v;
        dm_norm = 1'b1; data1_norm = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check8("R1 rdata", reg_rdata, 8'h00);
        pins("R1 pins", 1'b1, 1'b0);
        rst_n = 1'b1;
        rd(8'h19, v); check8("R1 carkit", v, 8'h00);
        rd(8'h16, v); check8("R1 scratch", v, 8'h00);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][23:16], VEC[i][15:8]);
            rd(VEC[i][23:16], v);
            check8((VEC[i][23:16] < 8'h19) ? "R2 vector" : "R3 vector", v, VEC[i][7:0]);
        end

        // R4 aliases and unmapped
        wr(8'h16, 8'h77);
        rd(8'h17, v); check8("R4 alias 17h", v, 8'h77);
        rd(8'h18, v); check8("R4 alias 18h", v, 8'h77);
        rd(8'h20, v); check8("R4 unmapped", v, 8'h00);
        rd(8'h15, v); check8("R4 unmapped low", v, 8'h00);

        // R7 bits stored but no route without carkit mode
        wr(8'h19, 8'h0C);
        data0_in = 1'b0; dp_in = 1'b1;
        pins("R7 no route", 1'b1, 1'b0);
        rd(8'h1A, v); check8("R7 readback", v, 8'h0C);

        // R5 R6 both routes
        carkit_mode = 1'b1;
        pins("R5 R6 route a", 1'b0, 1'b1);
        data0_in = 1'b1; dp_in = 1'b0;
        pins("R5 R6 route b", 1'b1, 1'b0);
        data0_in = 1'b0; dm_norm = 1'b1; data1_norm = 1'b1;
        pins("R5 R6 ignore norm", 1'b0, 1'b0);

        // R8 writes ignored during passthrough, rdata holds
        v = reg_rdata;
        wr(8'h16, 8'h11);
        wr(8'h1B, 8'h0C);
        check8("R8 rdata hold", reg_rdata, v);
        pins("R8 still routed", 1'b0, 1'b0);

        // R9 stop ends passthrough
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        pins("R9 fallback", 1'b1, 1'b1);
        rd(8'h19, v); check8("R9 bits cleared", v, 8'h00);
        rd(8'h16, v); check8("R8 scratch kept", v, 8'h77);

        // R6 receive only, transmit falls back
        carkit_mode = 1'b0;
        wr(8'h19, 8'h08);
        carkit_mode = 1'b1; dp_in = 1'b0; data0_in = 1'b0;
        dm_norm = 1'b1; data1_norm = 1'b1;
        pins("R6 rx only", 1'b1, 1'b0);

        // R9 reset during passthrough
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        pins("R9 reset fallback", 1'b1, 1'b1);
        rd(8'h19, v); check8("R9 reset clears", v, 8'h00);

        // R10 scratch affects no pin
        wr(8'h16, 8'hFF);
        dm_norm = 1'b0; data1_norm = 1'b1; data0_in = 1'b1; dp_in = 1'b0;
        pins("R10 scratch inert", 1'b0, 1'b1);
        rd(8'h18, v); check8("R10 scratch value", v, 8'hFF);

        carkit_mode = 1'b0;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule